// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the slave side of a synchronous 32-bit bus on which one set of lines carries the address first and the data afterwards. An initiator raises `frame_i` to open a transaction. In that first cycle the shared lines hold a byte address and the 4-bit control field holds a command code. When the address does not fit in 32 bits, the initiator first sends a dual-cycle command and then the two halves of the address on consecutive cycles. Once the address phase is over, the control field is reused as per-byte lane enables.

On a memory read or write that falls inside its window, the block claims the transaction and serves one or more data words from a small internal register file. The first word can be delayed by a programmable number of wait states. The word address moves up by 4 after every transferred word. When a burst reaches the last word of the window, the block signals stop so that the burst cannot run past the window. The initiator drops `frame_i` on the last data phase, and the block then returns to idle.

Top module: `mux_bus_target`

## Requirements
- R1: After reset, `devsel_o`, `trdy_o`, `stop_o` and `ad_oe_o` are low and every register word reads as 0.
- R2: An address phase is the cycle in which `frame_i` is high while the block is idle. Command 4'b0110 (memory read) or 4'b0111 (memory write) with a byte address inside [BASE_ADDR, BASE_ADDR + 4*WIN_WORDS) claims the transaction. `devsel_o` is then high from the next cycle until the transaction ends.
- R3: Any other command, for example 4'b0010 or 4'b0011 (I/O read/write), or an address outside the window, leaves `devsel_o`, `trdy_o` and `ad_oe_o` low and the registers unchanged.
- R4: Command 4'b1101 in the address phase marks a dual-cycle address. `ad_i` holds the low half in that cycle. In the next cycle `ad_i` holds the high half and `cbe_i` holds the real command. The full 64-bit address is compared against the window.
- R5: `trdy_o` first rises `lat_i` cycles after the first data cycle. Later words of the same burst get no wait states.
- R6: A word transfers only in a cycle where `irdy_i` and `trdy_o` are both high. The word address advances by 4 after each transfer.
- R7: On a write transfer, byte k of the addressed word takes `ad_i[8k+7:8k]` when `cbe_i[k]` is 1 and keeps its old value when `cbe_i[k]` is 0.
- R8: During the data cycles of a read, `ad_oe_o` is high and `ad_o` shows the word at the current address.
- R9: While the current word is the last word of the window, `stop_o` is high together with `trdy_o`. If that word transfers with `frame_i` still high, `stop_o` stays high and `trdy_o` stays low until `frame_i` falls. No further word is written or read.
- R10: A transfer with `frame_i` low is the last one: in the next cycle `devsel_o` and `trdy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Transaction in progress; low on the final data phase |
| irdy_i | input | 1 | Initiator ready |
| ad_i | input | 32 | Shared address/data lines, inbound |
| cbe_i | input | 4 | Command in address phase, byte enables in data phases |
| lat_i | input | LAT_W | Wait states before the first data word |
| ad_o | output | 32 | Read data driven onto the shared lines |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| devsel_o | output | 1 | Transaction claimed |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Target requests termination |

## Verification
The bound checker runs on every cycle. It checks that ready, stop and the output enable appear only while the transaction is claimed, and that the block lets go of the bus right after a final transfer. It checks that the read word holds steady while no word moves, and that a stop handshake with frame still high leads into the hold state. The number of wait states, byte-lane merging, the address order within a burst, the dual-cycle address match and the fact that missed or foreign commands leave the registers unchanged are data-dependent. Only the bench shows these, through its cycle-by-cycle model and its read-back scenarios.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR_HI, ST_DATA, ST_DRAIN, ST_SKIP
  } mbt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_DUAL   = 4'b1101;
endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
  import mbt_pkg::*;
#(
  parameter logic [63:0] BASE_ADDR = 64'h1000,
  parameter int unsigned WIN_WORDS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [63:0]      addr_i,
  input  logic [3:0]       cmd_i,
  output logic             hit_o,
  output logic             rd_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [63:0] SPAN = 64'(WIN_WORDS) * 64'd4;

  logic [63:0] off;
  logic        cmd_ok;

  always_comb begin
    off    = addr_i - BASE_ADDR;
    cmd_ok = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_WR);
    hit_o  = cmd_ok && (addr_i >= BASE_ADDR) && (off < SPAN);
    rd_o   = (cmd_i == CMD_MEM_RD);
    idx_o  = off[IDX_W+1:2];
  end
endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile #(
  parameter int unsigned WIN_WORDS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] mem_q [WIN_WORDS];

  for (genvar w = 0; w < WIN_WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          mem_q[w][8*b+:8] <= 8'h00;
        else if (we_i && be_i[b] && (widx_i == IDX_W'(w)))
          mem_q[w][8*b+:8] <= wdata_i[8*b+:8];
      end
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
  import mbt_pkg::*;
#(
  parameter logic [63:0] BASE_ADDR = 64'h1000,
  parameter int unsigned WIN_WORDS = 8,
  parameter int unsigned LAT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             irdy_i,
  input  logic [31:0]      ad_i,
  input  logic [3:0]       cbe_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [31:0]      ad_o,
  output logic             ad_oe_o,
  output logic             devsel_o,
  output logic             trdy_o,
  output logic             stop_o
);
  localparam int unsigned IDX_W = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_WORDS - 1);

  mbt_state_e       state_q;
  logic [31:0]      lo_q;
  logic [LAT_W-1:0] wait_q;
  logic [IDX_W-1:0] idx_q;
  logic             rd_q;

  logic [63:0]      dec_addr;
  logic             dec_hit, dec_rd;
  logic [IDX_W-1:0] dec_idx;
  logic             xfer, at_last;

  assign dec_addr = (state_q == ST_ADDR_HI) ? {ad_i, lo_q} : {32'h0, ad_i};

  mbt_decode #(
    .BASE_ADDR(BASE_ADDR), .WIN_WORDS(WIN_WORDS), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(dec_addr), .cmd_i(cbe_i),
    .hit_o(dec_hit), .rd_o(dec_rd), .idx_o(dec_idx)
  );

  assign trdy_o   = (state_q == ST_DATA) && (wait_q == '0);
  assign at_last  = (idx_q == LAST_IDX);
  assign stop_o   = (state_q == ST_DRAIN) || (trdy_o && at_last);
  assign devsel_o = (state_q == ST_DATA) || (state_q == ST_DRAIN);
  assign ad_oe_o  = (state_q == ST_DATA) && rd_q;
  assign xfer     = trdy_o && irdy_i;

  mbt_regfile #(.WIN_WORDS(WIN_WORDS), .IDX_W(IDX_W)) u_rf (
    .clk_i, .rst_ni,
    .we_i(xfer && !rd_q), .widx_i(idx_q), .be_i(cbe_i), .wdata_i(ad_i),
    .ridx_i(idx_q), .rdata_o(ad_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lo_q    <= '0;
      wait_q  <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_ADDR_HI: begin
          if (state_q == ST_IDLE && frame_i && cbe_i == CMD_DUAL) begin
            lo_q    <= ad_i;
            state_q <= ST_ADDR_HI;
          end else if (state_q == ST_ADDR_HI || frame_i) begin
            if (dec_hit) begin
              state_q <= ST_DATA;
              wait_q  <= lat_i;
              idx_q   <= dec_idx;
              rd_q    <= dec_rd;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
          end else if (irdy_i) begin
            if (!frame_i)     state_q <= ST_IDLE;
            else if (at_last) state_q <= ST_DRAIN;
            else              idx_q   <= idx_q + 1'b1;
          end
        end
        ST_DRAIN, ST_SKIP: begin
          if (!frame_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbt_chk.sv
module mbt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        frame_i,
  input logic        irdy_i,
  input logic [31:0] ad_o,
  input logic        ad_oe_o,
  input logic        devsel_o,
  input logic        trdy_o,
  input logic        stop_o
);
  // R3
  unclaimed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !devsel_o |-> (!trdy_o && !stop_o && !ad_oe_o));

  // R5
  ready_claimed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_o |-> devsel_o);

  // R10
  final_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_o && irdy_i && !frame_i) |=> (!devsel_o && !trdy_o));

  // R9
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && trdy_o && irdy_i && frame_i) |=> (stop_o && !trdy_o && devsel_o));

  // R8
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && !(trdy_o && irdy_i)) |=> $stable(ad_o));

  // R2
  stop_claimed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> devsel_o);
endmodule

bind mux_bus_target mbt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .irdy_i(irdy_i),
  .ad_o(ad_o), .ad_oe_o(ad_oe_o), .devsel_o(devsel_o),
  .trdy_o(trdy_o), .stop_o(stop_o)
);

// File: tb/sim_mux_bus_target.sv
`timescale 1ns/1ps
module sim_mux_bus_target;
  localparam logic [63:0] BASE = 64'h1000;
  localparam int WORDS = 8;

  logic        clk = 0, rst_n = 0;
  logic        frame = 0, irdy = 0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic [3:0]  lat = '0;
  logic [31:0] ad_o;
  logic        ad_oe, devsel, trdy, stop;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #4 clk = ~clk;

  mux_bus_target #(.BASE_ADDR(BASE), .WIN_WORDS(WORDS), .LAT_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .irdy_i(irdy), .ad_i(ad),
    .cbe_i(cbe), .lat_i(lat), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .devsel_o(devsel), .trdy_o(trdy), .stop_o(stop)
  );

  // behavioural model: 0 idle, 1 second address, 2 data, 3 hold-stop, 4 not ours
  int          m_st = 0, m_wait = 0, m_idx = 0;
  bit          m_rd = 0;
  logic [31:0] m_lo = '0;
  logic [31:0] m_mem [WORDS];
  logic [31:0] wq [$];
  logic [31:0] rq [$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_claim(input logic [63:0] a, input logic [3:0] c);
    if ((c == 4'b0110 || c == 4'b0111) && a >= BASE && a < BASE + 4*WORDS) begin
      m_st = 2; m_wait = int'(lat); m_idx = int'((a - BASE) / 4); m_rd = (c == 4'b0110);
    end else m_st = 4;
  endtask

  task automatic m_update();
    case (m_st)
      0: if (frame) begin
           if (cbe == 4'b1101) begin m_lo = ad; m_st = 1; end
           else m_claim({32'h0, ad}, cbe);
         end
      1: m_claim({ad, m_lo}, cbe);
      2: if (m_wait > 0) m_wait--;
         else if (irdy) begin
           if (!m_rd)
             for (int b = 0; b < 4; b++) if (cbe[b]) m_mem[m_idx][8*b+:8] = ad[8*b+:8];
           if (!frame) m_st = 0;
           else if (m_idx == WORDS-1) m_st = 3;
           else m_idx++;
         end
      default: if (!frame) m_st = 0;
    endcase
  endtask

  task automatic m_compare();
    bit e_tr, e_dev, e_stop, e_oe;
    e_dev  = (m_st == 2 || m_st == 3);
    e_tr   = (m_st == 2 && m_wait == 0);
    e_stop = (m_st == 3) || (e_tr && m_idx == WORDS-1);
    e_oe   = (m_st == 2 && m_rd);
    chk("R2 devsel", 64'(devsel), 64'(e_dev));
    chk("R5 trdy", 64'(trdy), 64'(e_tr));
    chk("R9 stop", 64'(stop), 64'(e_stop));
    chk("R8 ad_oe", 64'(ad_oe), 64'(e_oe));
    if (e_oe) chk("R8 ad_o", 64'(ad_o), 64'(m_mem[m_idx]));
  endtask

  task automatic step();
    @(posedge clk);
    m_update();
    @(negedge clk);
    m_compare();
  endtask

  // one transaction; wq holds write data, rq collects read data
  task automatic xact(input logic [3:0] cmd, input logic [63:0] addr, input bit dual,
                      input int n, input logic [3:0] be, input int l, input int gap_at,
                      output int moved, output int first_rdy);
    int i = 0, cyc = 0;
    bit gapped = 0, t;
    moved = 0; first_rdy = -1;
    lat = 4'(l);
    frame = 1; irdy = 0;
    if (dual) begin
      ad = addr[31:0]; cbe = 4'b1101; step();
      ad = addr[63:32]; cbe = cmd; step();
    end else begin
      ad = addr[31:0]; cbe = cmd; step();
    end
    while (i < n) begin
      if (!devsel) break;
      if (trdy && first_rdy < 0) first_rdy = cyc;
      frame = (i < n-1);
      irdy  = !(i == gap_at && !gapped);
      if (!irdy && trdy) gapped = 1;
      cbe = be;
      ad  = (cmd == 4'b0111 && i < wq.size()) ? wq[i] : 32'h0;
      t = irdy && trdy;
      if (t && cmd == 4'b0110) rq.push_back(ad_o);
      if (t && stop && frame) begin
        step(); moved++; break;
      end
      step();
      cyc++;
      if (t) begin i++; moved++; end
    end
    frame = 0; irdy = 0; cbe = 0; ad = 0;
    step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int mv, fr;
    for (int w = 0; w < WORDS; w++) m_mem[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 devsel", 64'(devsel), 0);
    chk("R1 trdy", 64'(trdy), 0);
    chk("R1 stop", 64'(stop), 0);
    chk("R1 ad_oe", 64'(ad_oe), 0);
    rq = {};
    xact(4'b0110, 64'h101C, 0, 1, 4'hF, 0, -1, mv, fr);
    chk("R1 reset word", 64'(rq[0]), 0);

    // R2/R6 burst write of four words
    wq = {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444};
    xact(4'b0111, 64'h1000, 0, 4, 4'hF, 0, -1, mv, fr);
    chk("R2 words moved", 64'(mv), 4);

    // R5/R6 burst read with two wait states and an initiator pause
    rq = {};
    xact(4'b0110, 64'h1000, 0, 4, 4'h0, 2, 1, mv, fr);
    chk("R5 first ready", 64'(fr), 2);
    for (int k = 0; k < 4; k++)
      chk("R6 burst order", 64'(rq[k]), 64'(32'h11111111 * (k + 1)));

    // R7 partial byte write: lanes 0 and 2
    wq = {32'hAABBCCDD};
    xact(4'b0111, 64'h1008, 0, 1, 4'b0101, 1, -1, mv, fr);
    rq = {};
    xact(4'b0110, 64'h1008, 0, 1, 4'h0, 0, -1, mv, fr);
    chk("R7 byte merge", 64'(rq[0]), 64'h33BB33DD);
    chk("R10 released", 64'(devsel), 0);

    // R3 I/O write and out-of-window write are not claimed
    wq = {32'hDEADBEEF};
    xact(4'b0011, 64'h1000, 0, 1, 4'hF, 0, -1, mv, fr);
    chk("R3 io ignored", 64'(mv), 0);
    xact(4'b0111, 64'h1020, 0, 1, 4'hF, 0, -1, mv, fr);
    chk("R3 miss ignored", 64'(mv), 0);
    rq = {};
    xact(4'b0110, 64'h1000, 0, 1, 4'h0, 0, -1, mv, fr);
    chk("R3 word kept", 64'(rq[0]), 64'h11111111);

    // R4 dual-cycle address: high half zero hits, nonzero misses
    wq = {32'h55555555};
    xact(4'b0111, 64'h0000_0000_0000_1010, 1, 1, 4'hF, 0, -1, mv, fr);
    chk("R4 dual hit", 64'(mv), 1);
    wq = {32'h66666666};
    xact(4'b0111, 64'h0000_0001_0000_1014, 1, 1, 4'hF, 0, -1, mv, fr);
    chk("R4 dual miss", 64'(mv), 0);
    rq = {};
    xact(4'b0110, 64'h1010, 0, 2, 4'h0, 0, -1, mv, fr);
    chk("R4 dual data", 64'(rq[0]), 64'h55555555);
    chk("R4 high half", 64'(rq[1]), 64'h0);

    // R9 burst running off the window end is stopped
    wq = {32'h77777777, 32'h88888888, 32'h99999999};
    xact(4'b0111, 64'h1018, 0, 3, 4'hF, 0, -1, mv, fr);
    chk("R9 words moved", 64'(mv), 2);
    rq = {};
    xact(4'b0110, 64'h1018, 0, 2, 4'h0, 0, -1, mv, fr);
    chk("R9 word6", 64'(rq[0]), 64'h77777777);
    chk("R9 word7", 64'(rq[1]), 64'h88888888);
    rq = {};
    xact(4'b0110, 64'h1000, 0, 1, 4'h0, 0, -1, mv, fr);
    chk("R9 no wrap", 64'(rq[0]), 64'h11111111);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule